// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation converter shared by several analogue inputs. Software writes one control word. The block divides the bus clock into a conversion clock and picks an input channel. It drives a sample strobe and a trial code towards an external comparator, then builds the result one bit per conversion clock from the comparator decision. Each finished result goes into that channel's own result register, together with a done flag and an overrun flag.

A conversion can be started in three ways: by a software command, by a chosen edge on one of six trigger lines, or continuously in burst mode. In burst mode the block steps through the enabled channels from the lowest to the highest and then wraps round. In burst mode the conversion can be shortened, giving fewer result bits. Results are always left-justified in the result field. Register access uses a plain single-cycle write strobe and a read strobe. Read data is registered.

Top module: `adc_scan_seq`

## Requirements
- R1: The conversion clock lasts DIV+1 bus cycles, where DIV is control bits [23:16]. The busy output is high for exactly (1 + number of result bits) × (DIV+1) consecutive bus cycles per conversion, and the trial code changes only on conversion clock ticks.
- R2: The first conversion clock samples. Each following clock tries one bit, starting at bit 9. `dac_code` shows the code on trial, and `cmp_in` = 1 keeps that bit. With a comparator that reports input ≥ trial, a full conversion returns the input value.
- R3: Writing address 0 with start code 1 (control bits [2:0]) starts one conversion on the lowest set bit of the channel mask (control bits [31:24]). An all-zero mask selects channel 0.
- R4: Start codes 2 to 7 start a conversion on an edge of `trig_in[code-2]`. Control bit 3 = 1 selects a falling edge and 0 selects a rising edge. The other polarity, and the other trigger lines, start nothing.
- R5: With burst mode on (control bit 5), conversions repeat without a command. The first uses the lowest set mask bit, and each later one uses the next higher set bit, wrapping to the lowest.
- R6: In burst mode, length code L (control bits [8:6]) gives 11−L conversion clocks and 10−L result bits, left-justified in result bits [9:0] with the low L bits zero.
- R7: Clearing burst mode while a conversion runs lets that conversion complete and store its result, and starts no further one.
- R8: While the enable bit (control bit 4) is 0, no conversion starts.
- R9: Reading address 8+k returns channel k's result in bits [9:0], its done flag in bit 16 and its overrun flag in bit 17, one cycle after the read strobe. A completed conversion sets the done flag, and the read clears both flags.
- R10: A result stored while its channel's done flag is still set raises that channel's overrun flag.
- R11: `sample_strb` is high during the first conversion clock of each conversion only, always within busy. Busy falls in the same cycle as the result becomes readable.
- R12: `irq` is high exactly while at least one channel's done flag is set.
- R13: After reset, busy, `sample_strb`, `irq`, `chan_sel` and `dac_code` are 0 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address: 0 control, 8+k result of channel k |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| trig_in | input | 6 | External start trigger lines |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| chan_sel | output | 3 | Input channel of the current or last conversion |
| sample_strb | output | 1 | High while the input is being sampled |
| busy | output | 1 | High while a conversion runs |
| dac_code | output | 10 | Trial code presented to the comparator |
| irq | output | 1 | Interrupt request, high while any done flag is set |

## Verification
The checks assume that the control word is not rewritten with a different channel mask or divider in the cycle in which a conversion begins. They also assume that a result register is never read in the same cycle as a result is stored into it. The stimulus keeps within these limits: it writes the control word only while the block is idle, or, to stop a burst, with an unchanged mask one conversion clock into a conversion. It reads result registers only after busy has fallen. The comparator is modelled as a plain comparison between each channel's input value and the trial code, so every expected result can be derived from the input value and the length code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } sar_state_t;

   localparam logic [2:0] START_NONE = 3'd0;
   localparam logic [2:0] START_NOW  = 3'd1;
   localparam logic [2:0] START_TRG0 = 3'd2;

   typedef struct packed {
      logic [7:0] mask;
      logic [7:0] div;
      logic [6:0] spare;
      logic [2:0] len;
      logic       burst;
      logic       enable;
      logic       fall;
      logic [2:0] start;
   } ctrl_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NCH  = 8,
   parameter int CH_W = 3
) (
   input  logic [NCH-1:0]  mask_i,
   input  logic [CH_W-1:0] last_i,
   output logic [CH_W-1:0] first_o,
   output logic [CH_W-1:0] next_o
);

   logic [NCH-1:0] eff;

   always_comb begin
      eff = (mask_i == '0) ? NCH'(1) : mask_i;
      first_o = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (eff[i]) first_o = CH_W'(i);
      end
      next_o = first_o;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (eff[i] && (i > int'(last_i))) next_o = CH_W'(i);
      end
   end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [IDX_W-1:0] lsb_i,
   input  logic             tick_i,
   input  logic             cmp_i,
   output logic             busy_o,
   output logic             sample_o,
   output logic [RES_W-1:0] dac_o,
   output logic             done_o,
   output logic [RES_W-1:0] result_o
);

   localparam logic [RES_W-1:0] ONE_HOT0 = RES_W'(1);
   localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);

   sar_state_t       state_q;
   logic [RES_W-1:0] acc_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] lsb_q;
   logic [RES_W-1:0] trial;
   logic             last_bit;

   assign trial    = acc_q | (ONE_HOT0 << idx_q);
   assign last_bit = (idx_q == lsb_q);
   assign busy_o   = (state_q != ST_IDLE);
   assign sample_o = (state_q == ST_SAMPLE);
   assign dac_o    = (state_q == ST_CONV) ? trial : '0;
   assign done_o   = (state_q == ST_CONV) && tick_i && last_bit;
   assign result_o = cmp_i ? trial : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         acc_q   <= '0;
         idx_q   <= '0;
         lsb_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go_i) begin
                  state_q <= ST_SAMPLE;
                  acc_q   <= '0;
                  idx_q   <= TOP_IDX;
                  lsb_q   <= lsb_i;
               end
            end
            ST_SAMPLE: begin
               if (tick_i) state_q <= ST_CONV;
            end
            ST_CONV: begin
               if (tick_i) begin
                  if (cmp_i) acc_q <= trial;
                  if (last_bit) state_q <= ST_IDLE;
                  else          idx_q   <= idx_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i) |=> $stable(dac_o));

   assert_busy_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_strobe_then_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && tick_i) |=> (dac_o == (ONE_HOT0 << TOP_IDX)));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH   = 8,
   parameter int RES_W = 10,
   parameter int CH_W  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_i,
   input  logic [CH_W-1:0]           wr_ch_i,
   input  logic [RES_W-1:0]          wr_data_i,
   input  logic                      rd_i,
   input  logic [CH_W-1:0]           rd_ch_i,
   output logic [NCH-1:0][RES_W-1:0] res_o,
   output logic [NCH-1:0]            done_o,
   output logic [NCH-1:0]            ovr_o
);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic wr_hit;
      logic rd_hit;
      assign wr_hit = wr_i && (wr_ch_i == CH_W'(c));
      assign rd_hit = rd_i && (rd_ch_i == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o[c]  <= '0;
            done_o[c] <= 1'b0;
            ovr_o[c]  <= 1'b0;
         end else if (wr_hit) begin
            res_o[c]  <= wr_data_i;
            done_o[c] <= 1'b1;
            ovr_o[c]  <= (ovr_o[c] | done_o[c]) & ~rd_hit;
         end else if (rd_hit) begin
            done_o[c] <= 1'b0;
            ovr_o[c]  <= 1'b0;
         end
      end
   end

   assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> done_o[$past(wr_ch_i)]);

   assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && done_o[wr_ch_i] && !(rd_i && (rd_ch_i == wr_ch_i)))
      |=> ovr_o[$past(wr_ch_i)]);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_seq_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int RES_W  = 10,
   parameter int NTRIG  = 6,
   parameter int DIV_W  = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NTRIG-1:0]  trig_in,
   input  logic              cmp_in,
   output logic [$clog2(NCH)-1:0] chan_sel,
   output logic              sample_strb,
   output logic              busy,
   output logic [RES_W-1:0]  dac_code,
   output logic              irq
);

   localparam int CH_W     = $clog2(NCH);
   localparam int IDX_W    = $clog2(RES_W);
   localparam int RES_BASE = 1 << (ADDR_W - 1);
   localparam int DONE_BIT = 16;
   localparam int OVR_BIT  = 17;

   if (NCH < 2 || NCH > 8) begin : g_bad_nch
      $error("NCH must lie between 2 and 8");
   end
   if (RES_W < 8 || RES_W > 16) begin : g_bad_res
      $error("RES_W must lie between 8 and 16");
   end
   if (NTRIG < 1 || NTRIG > 6) begin : g_bad_trig
      $error("NTRIG must lie between 1 and 6");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie between 1 and 8");
   end
   if (ADDR_W < CH_W + 1) begin : g_bad_addr
      $error("ADDR_W too small for the result window");
   end

   ctrl_t            ctrl_q;
   logic             sw_pend_q;
   logic [NTRIG-1:0] trig_q;
   logic [CH_W-1:0]  last_q;
   logic [CH_W-1:0]  chan_q;
   logic [CH_W-1:0]  first_ch;
   logic [CH_W-1:0]  next_ch;
   logic             edge_hit;
   logic             go;
   logic             tick;
   logic             res_valid;
   logic [RES_W-1:0] res_data;
   logic [IDX_W-1:0] lsb_sel;
   logic             wr_ctrl;
   logic             rd_res;
   logic [CH_W-1:0]  rd_ch;
   logic [NCH-1:0][RES_W-1:0] res_all;
   logic [NCH-1:0]   done_all;
   logic [NCH-1:0]   ovr_all;
   logic [31:0]      res_word;

   assign wr_ctrl = reg_wr && (reg_addr == '0);
   assign rd_ch   = CH_W'(int'(reg_addr) - RES_BASE);
   assign rd_res  = reg_rd && (int'(reg_addr) >= RES_BASE)
                           && (int'(reg_addr) - RES_BASE < NCH);

   always_comb begin
      int k;
      edge_hit = 1'b0;
      k = int'(ctrl_q.start) - int'(START_TRG0);
      if (ctrl_q.start >= START_TRG0 && k < NTRIG) begin
         edge_hit = ctrl_q.fall ? (trig_q[k] & ~trig_in[k])
                                : (~trig_q[k] & trig_in[k]);
      end
   end

   assign go      = !busy && ctrl_q.enable && (ctrl_q.burst || sw_pend_q || edge_hit);
   assign lsb_sel = ctrl_q.burst ? IDX_W'(ctrl_q.len) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         sw_pend_q <= 1'b0;
         trig_q    <= '0;
         last_q    <= CH_W'(NCH - 1);
         chan_q    <= '0;
      end else begin
         trig_q <= trig_in;
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
         if (go || !ctrl_q.enable) sw_pend_q <= 1'b0;
         if (wr_ctrl && reg_wdata[2:0] == START_NOW) sw_pend_q <= 1'b1;
         if (go) chan_q <= ctrl_q.burst ? next_ch : first_ch;
         if (!ctrl_q.burst) last_q <= CH_W'(NCH - 1);
         else if (go)       last_q <= next_ch;
      end
   end

   adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
      .mask_i  (ctrl_q.mask[NCH-1:0]),
      .last_i  (last_q),
      .first_o (first_ch),
      .next_o  (next_ch)
   );

   adc_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy),
      .div_i  (ctrl_q.div[DIV_W-1:0]),
      .tick_o (tick)
   );

   adc_sar_core #(.RES_W(RES_W), .IDX_W(IDX_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go),
      .lsb_i    (lsb_sel),
      .tick_i   (tick),
      .cmp_i    (cmp_in),
      .busy_o   (busy),
      .sample_o (sample_strb),
      .dac_o    (dac_code),
      .done_o   (res_valid),
      .result_o (res_data)
   );

   adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (res_valid),
      .wr_ch_i   (chan_q),
      .wr_data_i (res_data),
      .rd_i      (rd_res),
      .rd_ch_i   (rd_ch),
      .res_o     (res_all),
      .done_o    (done_all),
      .ovr_o     (ovr_all)
   );

   always_comb begin
      res_word = '0;
      res_word[RES_W-1:0] = res_all[rd_ch];
      res_word[DONE_BIT]  = done_all[rd_ch];
      res_word[OVR_BIT]   = ovr_all[rd_ch];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         if (reg_addr == '0) reg_rdata <= ctrl_q;
         else if (rd_res)    reg_rdata <= res_word;
         else                reg_rdata <= '0;
      end
   end

   assign chan_sel = chan_q;
   assign irq      = |done_all;

   assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.enable && !busy) |=> !busy);

   assert_chan_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ctrl_q.mask[chan_q]
                       || (ctrl_q.mask[NCH-1:0] == '0 && chan_q == '0)));

   assert_irq_follows_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> irq);

endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  trig_in = '0;
   logic        cmp_in;
   logic [2:0]  chan_sel;
   logic        sample_strb;
   logic        busy;
   logic [9:0]  dac_code;
   logic        irq;
   logic [9:0]  vin [8];

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   assign cmp_in = (vin[chan_sel] >= dac_code);

   adc_scan_seq u0 (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .trig_in, .cmp_in, .chan_sel, .sample_strb, .busy, .dac_code, .irq
   );

   // {mask[8], div[8], expected channel[3], input value[10]}
   localparam logic [28:0] VECS [6] = '{
      {8'h01, 8'd0, 3'd0, 10'h2A5},
      {8'h10, 8'd2, 3'd4, 10'h3FF},
      {8'h00, 8'd1, 3'd0, 10'h000},
      {8'h88, 8'd0, 3'd3, 10'h155},
      {8'h80, 8'd3, 3'd7, 10'h200},
      {8'h40, 8'd0, 3'd6, 10'h001}
   };

   function automatic logic [31:0] mk(input logic [7:0] mask, input logic [7:0] div,
                                      input logic [2:0] len, input logic burst,
                                      input logic en, input logic fall,
                                      input logic [2:0] start);
      return {mask, div, 7'b0, len, burst, en, fall, start};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wait_rise(output int ch);
      int n = 0;
      while (!busy && n < 200) begin
         @(negedge clk);
         n++;
      end
      ch = busy ? int'(chan_sel) : -1;
   endtask

   task automatic count_busy(output int cyc, output int samp);
      cyc = 0; samp = 0;
      while (busy) begin
         cyc++;
         if (sample_strb) samp++;
         @(negedge clk);
      end
   endtask

   task automatic no_busy(input int n, output int seen);
      seen = 0;
      repeat (n) begin
         @(negedge clk);
         if (busy) seen = 1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int ch, cyc, samp, seen;
      for (int i = 0; i < 8; i++) vin[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state
      chk("R13 busy", busy, 0);
      chk("R13 sample_strb", sample_strb, 0);
      chk("R13 irq", irq, 0);
      chk("R13 chan_sel", chan_sel, 0);
      chk("R13 dac_code", dac_code, 0);
      rd(4'd0, d);
      chk("R13 control word", d, 0);

      // Table: software starts (R1 R2 R3 R9 R11 R12)
      for (int v = 0; v < 6; v++) begin
         logic [7:0] m, dv;
         logic [2:0] ec;
         logic [9:0] x;
         {m, dv, ec, x} = VECS[v];
         vin[ec] = x;
         wr(4'd0, mk(m, dv, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1));
         wait_rise(ch);
         chk("R3 channel", ch, int'(ec));
         count_busy(cyc, samp);
         chk("R1 busy length", cyc, 11 * (int'(dv) + 1));
         chk("R11 sample length", samp, int'(dv) + 1);
         chk("R12 irq set", irq, 1);
         rd(4'd8 + 4'(ec), d);
         chk("R2 result", int'(d[9:0]), int'(x));
         chk("R9 done set", d[16], 1);
         chk("R12 irq cleared", irq, 0);
         rd(4'd8 + 4'(ec), d);
         chk("R9 done cleared by read", d[16], 0);
      end

      // R4: edge starts
      vin[1] = 10'h0F0;
      wr(4'd0, mk(8'h02, 8'd0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd3));
      @(negedge clk); trig_in[1] = 1'b1;
      @(negedge clk); trig_in[0] = 1'b1;
      @(negedge clk); trig_in[0] = 1'b0;
      no_busy(15, seen);
      chk("R4 wrong polarity or line ignored", seen, 0);
      trig_in[1] = 1'b0;
      wait_rise(ch);
      chk("R4 falling edge starts", ch, 1);
      count_busy(cyc, samp);
      chk("R4 length", cyc, 11);
      rd(4'd9, d);
      chk("R4 result", int'(d[9:0]), 'h0F0);
      wr(4'd0, mk(8'h02, 8'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd7));
      no_busy(5, seen);
      chk("R4 no start without edge", seen, 0);
      trig_in[5] = 1'b1;
      wait_rise(ch);
      chk("R4 rising edge on line 5", ch, 1);
      count_busy(cyc, samp);
      rd(4'd9, d);
      chk("R4 second result", d[16], 1);
      trig_in[5] = 1'b0;

      // R8: disabled
      wr(4'd0, mk(8'h01, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd1));
      no_busy(30, seen);
      chk("R8 software start blocked", seen, 0);
      wr(4'd0, mk(8'h01, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0));
      no_busy(30, seen);
      chk("R8 burst blocked", seen, 0);
      wr(4'd0, 32'd0);
      for (int c = 0; c < 8; c++) rd(4'd8 + 4'(c), d);
      chk("R12 irq idle", irq, 0);

      // R5 R6 R7 R10: burst scan
      vin[2] = 10'h3C7; vin[5] = 10'h1FF; vin[7] = 10'h2AB;
      wr(4'd0, mk(8'hA4, 8'd0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0));
      wait_rise(ch);
      chk("R5 first channel", ch, 2);
      count_busy(cyc, samp);
      chk("R6 shortened length", cyc, 8);
      wait_rise(ch);
      chk("R5 second channel", ch, 5);
      count_busy(cyc, samp);
      wait_rise(ch);
      chk("R5 third channel", ch, 7);
      count_busy(cyc, samp);
      wait_rise(ch);
      chk("R5 wrap to lowest", ch, 2);
      wr(4'd0, mk(8'hA4, 8'd0, 3'd3, 1'b0, 1'b1, 1'b0, 3'd0));
      count_busy(cyc, samp);
      no_busy(40, seen);
      chk("R7 no conversion after burst cleared", seen, 0);
      rd(4'd10, d);
      chk("R6 ch2 left-justified", int'(d[9:0]), 'h3C0);
      chk("R7 last conversion stored", d[16], 1);
      chk("R10 overrun set", d[17], 1);
      rd(4'd13, d);
      chk("R6 ch5 left-justified", int'(d[9:0]), 'h1F8);
      chk("R10 no overrun on single result", d[17], 0);
      rd(4'd15, d);
      chk("R6 ch7 left-justified", int'(d[9:0]), 'h2A8);
      rd(4'd10, d);
      chk("R9 read cleared flags", int'(d[17:16]), 0);
      chk("R12 irq after reads", irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule